// File: doc/BRIEF.md
# Permission-Tracking Set-Associative Tag Store

This block holds the tags of one cache level, arranged as sets of ways. Each way carries a tag, a two-bit coherence permission, an optional lock owner context and a small block of byte data. A single command port accepts one operation per cycle. The operations are access checks, presence and room queries, line allocation and release, a conflict probe, permission updates, lock handling and partial byte reads and writes. The response to each operation arrives in a register one cycle later.

A coherence controller uses the block in this way. It first asks whether an access may proceed. On a miss it asks whether the set has room. If the set is full, it probes for the line to evict. It then allocates the new line and moves the line through its permission states as the protocol requires. A tree pseudo-LRU per set picks victims. An empty way always wins over the tree choice.

Top module: `perm_tag_store`

## Requirements
- R1: After reset, every way of every set is empty (permission NONE = 0), no lock is held, every tree bit is 0, and `rsp_valid` is low until a command is accepted.
- R2: The set index is taken from the address bits just above the byte offset, and the tag from the bits above those. A command is accepted when `cmd_valid` is high at a clock edge, and `rsp_valid` follows one cycle later. Presence test (op 2) hits only when a way of the set holds the tag with a permission other than NONE.
- R3: Access check (op 1) hits when the matched line is READ_WRITE (3), or when it is READ_ONLY (2) and the request kind is load (0) or fetch (1). Store (2) on a READ_ONLY line misses, and INVALID (1) never hits.
- R4: Any tag match on an access check marks that way most recently used, even when the permission denies the access.
- R5: Room query (op 3) hits when the tag is present or the set has an empty way.
- R6: Allocate (op 4) fills the lowest-numbered empty way, writes the tag, sets permission INVALID, drops the lock and marks the way most recently used. `rsp_way` gives that way. With the tag already present or no way empty, it sets `rsp_err` and changes nothing.
- R7: Release (op 5) empties the matched way and drops its lock.
- R8: Conflict probe (op 6) reports the way that would be replaced. With no empty way it sets `rsp_hit` and returns the full line address (tag, set, zero offset) held in the tree victim. Otherwise `rsp_hit` is low and `rsp_way` is the lowest empty way.
- R9: Permission update (op 7) writes `cmd_perm` to the matched line and drops its lock.
- R10: Lock set (op 8) records `cmd_ctx` as owner, and lock clear (op 9) drops it. Lock test (op 10) hits only when a lock is held and its owner equals `cmd_ctx`.
- R11: Byte read (op 11) and byte write (op 12) cover `cmd_size` consecutive bytes starting at the address offset. Read data is packed from byte 0 of `rsp_data`, and unused bytes are zero. A size of 0, a size above the transfer width, or a window past the line end sets `rsp_err` and writes nothing.
- R12: Release, permission update, the lock operations and the byte operations set `rsp_err` and change no state when the tag is not present. `rsp_perm` returns the matched permission, or NONE.
- R13: Each set keeps WAYS-1 tree bits over the ways, with the lower half on the left. A bit of 1 points right. Touching a way sets each bit on its path to point to the other half. The tree victim is found by following the bits from the root. Touches happen only on an access-check match and a successful allocate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Operation code |
| cmd_req | input | 2 | Access request kind |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_perm | input | 2 | New permission for op 7 |
| cmd_ctx | input | CTX_W | Lock context |
| cmd_size | input | $clog2(XFER_BYTES+1) | Byte count for ops 11 and 12 |
| cmd_wdata | input | 8*XFER_BYTES | Write bytes, packed from byte 0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Operation result flag |
| rsp_err | output | 1 | Illegal or failed operation |
| rsp_way | output | $clog2(WAYS) | Matched, filled or victim way |
| rsp_perm | output | 2 | Permission of matched line |
| rsp_addr | output | ADDR_W | Victim line address from probe |
| rsp_data | output | 8*XFER_BYTES | Read bytes |

## Verification
The bench builds the block with 4 sets of 4 ways, 8-byte lines, 16-bit addresses, 3-bit contexts and 4-byte transfers. It draws tags from a pool of six, so sets fill often. That makes full-set allocation failures, tree-victim probes and reuse of released ways common. Byte windows of size 0 to 5 at any offset exercise both legal spans and spans that run past the line end. Lock owners from a small context range make both matching and non-matching lock tests frequent.

// File: rtl/perm_tag_pkg.sv
package perm_tag_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_INV  = 2'd1,
    PERM_RD   = 2'd2,
    PERM_RW   = 2'd3
  } line_perm_e;

  typedef enum logic [1:0] {
    REQ_LOAD  = 2'd0,
    REQ_FETCH = 2'd1,
    REQ_STORE = 2'd2,
    REQ_RSVD  = 2'd3
  } req_kind_e;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_ACCESS    = 4'd1,
    OP_PRESENT   = 4'd2,
    OP_ROOM      = 4'd3,
    OP_ALLOC     = 4'd4,
    OP_RELEASE   = 4'd5,
    OP_PROBE     = 4'd6,
    OP_SETPERM   = 4'd7,
    OP_LOCK_SET  = 4'd8,
    OP_LOCK_CLR  = 4'd9,
    OP_LOCK_TEST = 4'd10,
    OP_RD_BYTES  = 4'd11,
    OP_WR_BYTES  = 4'd12
  } tag_op_e;

  // read-only lines serve loads and fetches, read-write lines serve all
  function automatic logic grants_access(line_perm_e p, req_kind_e r);
    return (p == PERM_RW) || ((p == PERM_RD) && (r == REQ_LOAD || r == REQ_FETCH));
  endfunction

  function automatic logic in_window(int idx, int base, int len);
    return (idx >= base) && (idx < base + len);
  endfunction

endpackage

// File: rtl/tag_way_match.sv
module tag_way_match
  import perm_tag_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20
) (
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0][1:0]        way_perm,
  input  logic [TAG_W-1:0]            req_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        any_hit,
  output logic [$clog2(WAYS)-1:0]     hit_way,
  output logic                        any_free,
  output logic [$clog2(WAYS)-1:0]     free_way
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] free_vec;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      free_vec[w] = (way_perm[w] == PERM_NONE);
      hit_vec[w]  = !free_vec[w] && (way_tag[w] == req_tag);
    end
    any_hit  = |hit_vec;
    any_free = |free_vec;
    hit_way  = '0;
    free_way = '0;
    // descending scan so the lowest index is the last one written
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (free_vec[w]) free_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tag_plru_tree.sv
module tag_plru_tree #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [$clog2(SETS)-1:0]  touch_set,
  input  logic [$clog2(WAYS)-1:0]  touch_way,
  input  logic [$clog2(SETS)-1:0]  look_set,
  output logic [$clog2(WAYS)-1:0]  victim_way
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  logic [NODES-1:0] tree_q [SETS];

  // heap numbering: node n has children 2n and 2n+1, bit n-1 holds its pointer
  function automatic logic [NODES-1:0] tree_touch(input logic [NODES-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    int unsigned n;
    logic d;
    tree_touch = t;
    n = 1;
    for (int l = 0; l < WAY_W; l++) begin
      d = w[WAY_W-1-l];
      tree_touch[n-1] = ~d;
      n = 2 * n + 32'(d);
    end
  endfunction

  function automatic logic [WAY_W-1:0] tree_victim(input logic [NODES-1:0] t);
    int unsigned n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + 32'(t[n-1]);
    return WAY_W'(n - WAYS);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      for (int s = 0; s < SETS; s++)
        if (touch_set == SET_W'(s)) tree_q[s] <= tree_touch(tree_q[s], touch_way);
    end
  end

  assign victim_way = tree_victim(tree_q[look_set]);

  AST_MRU_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (tree_victim(tree_q[$past(touch_set)]) != $past(touch_way))); // R13

endmodule

// File: rtl/tag_line_data.sv
module tag_line_data
  import perm_tag_pkg::*;
#(
  parameter int SETS        = 16,
  parameter int WAYS        = 4,
  parameter int BLOCK_BYTES = 16,
  parameter int XFER_BYTES  = 4
) (
  input  logic                             clk,
  input  logic                             wr_en,
  input  logic [$clog2(SETS)-1:0]          sel_set,
  input  logic [$clog2(WAYS)-1:0]          sel_way,
  input  logic [$clog2(BLOCK_BYTES)-1:0]   off,
  input  logic [$clog2(XFER_BYTES+1)-1:0]  len,
  input  logic [8*XFER_BYTES-1:0]          wdata,
  output logic [8*XFER_BYTES-1:0]          rdata
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);

  logic [7:0] mem [SETS][WAYS][BLOCK_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BLOCK_BYTES; b++) begin
        if (in_window(b, int'(off), int'(len)))
          mem[sel_set][sel_way][OFF_W'(b)] <= wdata[8*(b - int'(off)) +: 8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < XFER_BYTES; k++) begin
      if (k < int'(len) && (int'(off) + k) < BLOCK_BYTES)
        rdata[8*k +: 8] = mem[sel_set][sel_way][OFF_W'(int'(off) + k)];
    end
  end

endmodule

// File: rtl/perm_tag_store.sv
module perm_tag_store
  import perm_tag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int NUM_SETS    = 16,
  parameter int WAYS        = 4,
  parameter int CTX_W       = 4,
  parameter int XFER_BYTES  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_valid,
  input  logic [3:0]                       cmd_op,
  input  logic [1:0]                       cmd_req,
  input  logic [ADDR_W-1:0]                cmd_addr,
  input  logic [1:0]                       cmd_perm,
  input  logic [CTX_W-1:0]                 cmd_ctx,
  input  logic [$clog2(XFER_BYTES+1)-1:0]  cmd_size,
  input  logic [8*XFER_BYTES-1:0]          cmd_wdata,
  output logic                             rsp_valid,
  output logic                             rsp_hit,
  output logic                             rsp_err,
  output logic [$clog2(WAYS)-1:0]          rsp_way,
  output logic [1:0]                       rsp_perm,
  output logic [ADDR_W-1:0]                rsp_addr,
  output logic [8*XFER_BYTES-1:0]          rsp_data
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int DATA_W = 8 * XFER_BYTES;

  // ---------------- address arithmetic ----------------
  function automatic logic [SET_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                   input logic [SET_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  function automatic logic span_fits(input logic [OFF_W-1:0] o, input int len);
    return (len >= 1) && (len <= XFER_BYTES) && (int'(o) + len <= BLOCK_BYTES);
  endfunction

  // ---------------- line state ----------------
  logic [TAG_W-1:0] tag_q      [NUM_SETS][WAYS];
  line_perm_e       perm_q     [NUM_SETS][WAYS];
  logic             lock_v_q   [NUM_SETS][WAYS];
  logic [CTX_W-1:0] lock_ctx_q [NUM_SETS][WAYS];

  // ---------------- request decode ----------------
  tag_op_e          op;
  req_kind_e        req_kind;
  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;

  assign op       = tag_op_e'(cmd_op);
  assign req_kind = req_kind_e'(cmd_req);
  assign req_set  = addr_set(cmd_addr);
  assign req_tag  = addr_tag(cmd_addr);
  assign req_off  = cmd_addr[OFF_W-1:0];

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0][1:0]       set_perms;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_tags[w]  = tag_q[req_set][WAY_W'(w)];
      set_perms[w] = perm_q[req_set][WAY_W'(w)];
    end
  end

  logic [WAYS-1:0]  hit_vec;
  logic             tag_hit;
  logic [WAY_W-1:0] hit_way;
  logic             has_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] tree_way;

  tag_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tag  (set_tags),
    .way_perm (set_perms),
    .req_tag  (req_tag),
    .hit_vec  (hit_vec),
    .any_hit  (tag_hit),
    .hit_way  (hit_way),
    .any_free (has_free),
    .free_way (free_way)
  );

  // ---------------- named internal events ----------------
  logic             needs_line;
  logic             is_bytes;
  logic             span_ok;
  logic             line_ok;
  logic             ev_access_match;
  logic             ev_alloc_ok;
  logic             ev_alloc_bad;
  logic             ev_release;
  logic             ev_setperm;
  logic             ev_lock_set;
  logic             ev_lock_clr;
  logic             ev_write;
  logic             ev_touch;
  logic [WAY_W-1:0] touch_way;
  logic [WAY_W-1:0] repl_way;
  line_perm_e       hit_perm;
  logic             lock_owned;

  assign is_bytes   = (op == OP_RD_BYTES) || (op == OP_WR_BYTES);
  assign needs_line = (op == OP_RELEASE) || (op == OP_SETPERM) || (op == OP_LOCK_SET) ||
                      (op == OP_LOCK_CLR) || (op == OP_LOCK_TEST) || is_bytes;
  assign span_ok    = span_fits(req_off, int'(cmd_size));
  assign line_ok    = cmd_valid && needs_line && tag_hit && (!is_bytes || span_ok);

  assign ev_access_match = cmd_valid && (op == OP_ACCESS) && tag_hit;
  assign ev_alloc_ok     = cmd_valid && (op == OP_ALLOC) && !tag_hit && has_free;
  assign ev_alloc_bad    = cmd_valid && (op == OP_ALLOC) && (tag_hit || !has_free);
  assign ev_release      = line_ok && (op == OP_RELEASE);
  assign ev_setperm      = line_ok && (op == OP_SETPERM);
  assign ev_lock_set     = line_ok && (op == OP_LOCK_SET);
  assign ev_lock_clr     = line_ok && (op == OP_LOCK_CLR);
  assign ev_write        = line_ok && (op == OP_WR_BYTES);

  assign ev_touch  = ev_access_match || ev_alloc_ok;
  assign touch_way = ev_alloc_ok ? free_way : hit_way;
  assign repl_way  = has_free ? free_way : tree_way;
  assign hit_perm  = tag_hit ? perm_q[req_set][hit_way] : PERM_NONE;
  assign lock_owned = lock_v_q[req_set][hit_way] && (lock_ctx_q[req_set][hit_way] == cmd_ctx);

  tag_plru_tree #(.SETS(NUM_SETS), .WAYS(WAYS)) u_plru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (ev_touch),
    .touch_set  (req_set),
    .touch_way  (touch_way),
    .look_set   (req_set),
    .victim_way (tree_way)
  );

  logic [DATA_W-1:0] line_rdata;

  tag_line_data #(
    .SETS(NUM_SETS), .WAYS(WAYS), .BLOCK_BYTES(BLOCK_BYTES), .XFER_BYTES(XFER_BYTES)
  ) u_data (
    .clk     (clk),
    .wr_en   (ev_write),
    .sel_set (req_set),
    .sel_way (hit_way),
    .off     (req_off),
    .len     (cmd_size),
    .wdata   (cmd_wdata),
    .rdata   (line_rdata)
  );

  // ---------------- state update ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]      <= '0;
          perm_q[s][w]     <= PERM_NONE;
          lock_v_q[s][w]   <= 1'b0;
          lock_ctx_q[s][w] <= '0;
        end
      end
    end else begin
      if (ev_alloc_ok) begin
        tag_q[req_set][free_way]    <= req_tag;
        perm_q[req_set][free_way]   <= PERM_INV;
        lock_v_q[req_set][free_way] <= 1'b0;
      end
      if (ev_release) begin
        perm_q[req_set][hit_way]   <= PERM_NONE;
        lock_v_q[req_set][hit_way] <= 1'b0;
      end
      if (ev_setperm) begin
        perm_q[req_set][hit_way]   <= line_perm_e'(cmd_perm);
        lock_v_q[req_set][hit_way] <= 1'b0;
      end
      if (ev_lock_set) begin
        lock_v_q[req_set][hit_way]   <= 1'b1;
        lock_ctx_q[req_set][hit_way] <= cmd_ctx;
      end
      if (ev_lock_clr) lock_v_q[req_set][hit_way] <= 1'b0;
    end
  end

  // ---------------- response ----------------
  logic              hit_n;
  logic              err_n;
  logic [WAY_W-1:0]  way_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;

  always_comb begin
    hit_n  = 1'b0;
    err_n  = ev_alloc_bad || (cmd_valid && needs_line && (!tag_hit || (is_bytes && !span_ok)));
    way_n  = tag_hit ? hit_way : '0;
    addr_n = '0;
    data_n = '0;
    unique case (op)
      OP_ACCESS:    hit_n = tag_hit && grants_access(hit_perm, req_kind);
      OP_PRESENT:   hit_n = tag_hit;
      OP_ROOM:      hit_n = tag_hit || has_free;
      OP_ALLOC: begin
        hit_n = ev_alloc_ok;
        way_n = repl_way;
      end
      OP_PROBE: begin
        hit_n = !has_free;
        way_n = repl_way;
        if (!has_free) addr_n = line_base(tag_q[req_set][tree_way], req_set);
      end
      OP_LOCK_TEST: hit_n = tag_hit && lock_owned;
      OP_RD_BYTES: begin
        hit_n = line_ok;
        if (line_ok) data_n = line_rdata;
      end
      OP_RELEASE, OP_SETPERM, OP_LOCK_SET, OP_LOCK_CLR, OP_WR_BYTES: hit_n = line_ok;
      default: hit_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_way   <= '0;
      rsp_perm  <= '0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_hit   <= cmd_valid && hit_n;
      rsp_err   <= err_n;
      rsp_way   <= way_n;
      rsp_perm  <= hit_perm;
      rsp_addr  <= addr_n;
      rsp_data  <= data_n;
    end
  end

  // ---------------- assertions ----------------
  AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(cmd_valid)); // R2

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R6

  AST_FULL_ALLOC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_ALLOC && !has_free) |=> (rsp_err && !rsp_hit)); // R6

  AST_STORE_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_ACCESS && req_kind == REQ_STORE && hit_perm != PERM_RW)
      |=> !rsp_hit); // R3

  AST_PERM_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setperm |=> !lock_v_q[$past(req_set)][$past(hit_way)]); // R9

  AST_ABSENT_LINE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && needs_line && !tag_hit) |=> rsp_err); // R12

endmodule

// File: tb/tb_perm_tag_store.sv
module tb_perm_tag_store;
  import perm_tag_pkg::*;

  localparam int ADDR_W = 16;
  localparam int BLK    = 8;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int CTX_W  = 3;
  localparam int XFER   = 4;
  localparam int OFF_W  = 3;
  localparam int SET_W  = 2;
  localparam int LVL    = 2;
  localparam int SIZE_W = $clog2(XFER + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_req = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [1:0] cmd_perm = '0;
  logic [CTX_W-1:0] cmd_ctx = '0;
  logic [SIZE_W-1:0] cmd_size = '0;
  logic [8*XFER-1:0] cmd_wdata = '0;
  logic rsp_valid, rsp_hit, rsp_err;
  logic [1:0] rsp_way;
  logic [1:0] rsp_perm;
  logic [ADDR_W-1:0] rsp_addr;
  logic [8*XFER-1:0] rsp_data;

  always #5 clk = ~clk;

  perm_tag_store #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLK), .NUM_SETS(SETS), .WAYS(WAYS),
    .CTX_W(CTX_W), .XFER_BYTES(XFER)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_req(cmd_req),
    .cmd_addr(cmd_addr), .cmd_perm(cmd_perm), .cmd_ctx(cmd_ctx), .cmd_size(cmd_size),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_way(rsp_way), .rsp_perm(rsp_perm), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // reference model
  int   m_tag  [SETS][WAYS];
  int   m_perm [SETS][WAYS];
  bit   m_lv   [SETS][WAYS];
  int   m_ctx  [SETS][WAYS];
  bit   m_tree [SETS][WAYS];
  logic [7:0] m_data  [SETS][WAYS][BLK];
  bit         m_known [SETS][WAYS][BLK];

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_tag[s][w] = 0; m_perm[s][w] = 0; m_lv[s][w] = 0; m_ctx[s][w] = 0;
        m_tree[s][w] = 0;
        for (int b = 0; b < BLK; b++) m_known[s][w][b] = 0;
      end
  endfunction

  // tree restated level by level: node at level l on the path of way w
  function automatic void m_touch(int s, int w);
    for (int l = 0; l < LVL; l++) begin
      int node = (1 << l) + (w >> (LVL - l));
      m_tree[s][node] = !((w >> (LVL - 1 - l)) & 1);
    end
  endfunction

  function automatic int m_victim(int s);
    int n = 1;
    for (int l = 0; l < LVL; l++) n = 2 * n + int'(m_tree[s][n]);
    return n - WAYS;
  endfunction

  function automatic string op_tag(int op);
    case (op)
      1: return "R3/R4";
      2: return "R2";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8/R13";
      7: return "R9";
      8, 9, 10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run_op(input int op, input int rq, input int addr, input int perm,
                        input int ctx, input int size, input logic [31:0] wd);
    int s, tg, off, hw, fw, vic, repl, hperm, e_way;
    bit hit, free, span, needs, e_hit, e_err, isb;
    longint e_addr;
    logic [31:0] e_data, mask;
    string et;
    s = (addr >> OFF_W) & (SETS - 1);
    tg = addr >> (OFF_W + SET_W);
    off = addr & (BLK - 1);
    hit = 0; hw = 0; free = 0; fw = 0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (m_perm[s][w] != 0 && m_tag[s][w] == tg) begin hit = 1; hw = w; end
      if (m_perm[s][w] == 0) begin free = 1; fw = w; end
    end
    vic = m_victim(s);
    repl = free ? fw : vic;
    hperm = hit ? m_perm[s][hw] : 0;
    isb = (op == 11 || op == 12);
    span = size >= 1 && size <= XFER && off + size <= BLK;
    needs = (op == 5 || op == 7 || op == 8 || op == 9 || op == 10 || isb);
    e_err = (op == 4 && (hit || !free)) || (needs && (!hit || (isb && !span)));
    e_way = (op == 4 || op == 6) ? repl : (hit ? hw : 0);
    e_addr = 0; e_data = 0; mask = 0;
    case (op)
      1: e_hit = hit && (hperm == 3 || (hperm == 2 && (rq == 0 || rq == 1)));
      2: e_hit = hit;
      3: e_hit = hit || free;
      4: e_hit = !hit && free;
      6: begin
        e_hit = !free;
        if (!free) e_addr = (m_tag[s][vic] << (OFF_W + SET_W)) | (s << OFF_W);
      end
      10: e_hit = hit && m_lv[s][hw] && m_ctx[s][hw] == ctx;
      default: e_hit = needs && !e_err;
    endcase
    if (op == 11 && !e_err)
      for (int k = 0; k < size; k++)
        if (m_known[s][hw][off + k]) begin
          e_data[8*k +: 8] = m_data[s][hw][off + k];
          mask[8*k +: 8] = 8'hff;
        end
    et = (op == 4) ? "R6" : (isb && hit && !span) ? "R11" : "R12";

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_req = 2'(rq); cmd_addr = ADDR_W'(addr);
    cmd_perm = 2'(perm); cmd_ctx = CTX_W'(ctx); cmd_size = SIZE_W'(size); cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2", "rsp_valid", rsp_valid, 1);
    chk(op_tag(op), "hit", rsp_hit, e_hit);
    chk(et, "err", rsp_err, e_err);
    chk(op_tag(op), "way", rsp_way, e_way);
    chk("R12", "perm", rsp_perm, hperm);
    chk(op_tag(op), "addr", rsp_addr, e_addr);
    if (op == 11) chk("R11", "data", rsp_data & mask, e_data);
    else chk("R11", "data", rsp_data, 0);

    if (op == 1 && hit) m_touch(s, hw);
    if (!e_err) begin
      case (op)
        4: begin m_tag[s][fw] = tg; m_perm[s][fw] = 1; m_lv[s][fw] = 0; m_touch(s, fw); end
        5: begin m_perm[s][hw] = 0; m_lv[s][hw] = 0; end
        7: begin m_perm[s][hw] = perm; m_lv[s][hw] = 0; end
        8: begin m_lv[s][hw] = 1; m_ctx[s][hw] = ctx; end
        9: m_lv[s][hw] = 0;
        12: for (int k = 0; k < size; k++) begin
              m_data[s][hw][off + k] = wd[8*k +: 8];
              m_known[s][hw][off + k] = 1;
            end
        default: ;
      endcase
    end
  endtask

  function automatic int mk_addr(int tg, int s, int off);
    return (tg << (OFF_W + SET_W)) | (s << OFF_W) | off;
  endfunction

  function automatic int pick_op(int r);
    if (r < 15) return 1;
    if (r < 20) return 2;
    if (r < 25) return 3;
    if (r < 45) return 4;
    if (r < 53) return 5;
    if (r < 60) return 6;
    if (r < 70) return 7;
    if (r < 76) return 8;
    if (r < 79) return 9;
    if (r < 85) return 10;
    if (r < 92) return 11;
    return 12;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7719));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk("R1", "rsp_hit after reset", rsp_hit, 0);

    // R1: empty after reset
    run_op(2, 0, mk_addr(3, 0, 0), 0, 0, 0, 0);
    run_op(3, 0, mk_addr(3, 0, 0), 0, 0, 0, 0);
    // R6: fill set 1 from way 0 upward, then overflow
    for (int t = 1; t <= 4; t++) run_op(4, 0, mk_addr(t, 1, 0), 0, 0, 0, 0);
    run_op(4, 0, mk_addr(5, 1, 0), 0, 0, 0, 0);
    run_op(4, 0, mk_addr(2, 1, 0), 0, 0, 0, 0);
    run_op(6, 0, mk_addr(5, 1, 0), 0, 0, 0, 0);
    // R3: read-only line refuses store, serves load and fetch; R4 touch on denial
    run_op(7, 0, mk_addr(1, 1, 0), 2, 0, 0, 0);
    run_op(1, 2, mk_addr(1, 1, 0), 0, 0, 0, 0);
    run_op(6, 0, mk_addr(5, 1, 0), 0, 0, 0, 0);
    run_op(1, 0, mk_addr(1, 1, 0), 0, 0, 0, 0);
    run_op(1, 1, mk_addr(1, 1, 0), 0, 0, 0, 0);
    run_op(1, 0, mk_addr(3, 1, 0), 0, 0, 0, 0);
    // R10 and R9: lock owner and its loss on permission change
    run_op(8, 0, mk_addr(2, 1, 0), 0, 5, 0, 0);
    run_op(10, 0, mk_addr(2, 1, 0), 0, 5, 0, 0);
    run_op(10, 0, mk_addr(2, 1, 0), 0, 4, 0, 0);
    run_op(7, 0, mk_addr(2, 1, 0), 3, 0, 0, 0);
    run_op(10, 0, mk_addr(2, 1, 0), 0, 5, 0, 0);
    run_op(1, 2, mk_addr(2, 1, 0), 0, 0, 0, 0);
    // R11: windows at the line end
    run_op(12, 0, mk_addr(1, 1, 0), 0, 0, 4, 32'hA1B2C3D4);
    run_op(12, 0, mk_addr(1, 1, 4), 0, 0, 4, 32'h11223344);
    run_op(12, 0, mk_addr(1, 1, 6), 0, 0, 3, 32'h00556677);
    run_op(11, 0, mk_addr(1, 1, 2), 0, 0, 4, 0);
    run_op(11, 0, mk_addr(1, 1, 7), 0, 0, 1, 0);
    run_op(11, 0, mk_addr(1, 1, 0), 0, 0, 0, 0);
    // R12: line operations on an absent tag
    run_op(9, 0, mk_addr(6, 1, 0), 0, 0, 0, 0);
    run_op(11, 0, mk_addr(6, 1, 0), 0, 0, 2, 0);
    // R7: release then reuse the lowest empty way
    run_op(5, 0, mk_addr(2, 1, 0), 0, 0, 0, 0);
    run_op(3, 0, mk_addr(6, 1, 0), 0, 0, 0, 0);
    run_op(6, 0, mk_addr(6, 1, 0), 0, 0, 0, 0);
    run_op(4, 0, mk_addr(6, 1, 0), 0, 0, 0, 0);

    // constrained random traffic over a small tag pool
    for (int i = 0; i < 3000; i++) begin
      int op = pick_op(int'($urandom_range(0, 99)));
      run_op(op, int'($urandom_range(0, 3)),
             mk_addr(int'($urandom_range(0, 5)), int'($urandom_range(0, SETS - 1)),
                     int'($urandom_range(0, BLK - 1))),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 5)), $urandom());
    end
    finish_run();
  end

endmodule